// File: doc/BRIEF.md
# Delay-Line Band Search Controller

This block picks the operating band of a multi-band delay line in a wide-range delay-locked loop. It runs on the reference clock. When it leaves reset it holds the analog loop in reset and asks for the control voltage to be charged to its top rail. It then starts a search in the fastest band and moves toward slower bands one step at a time until the loop is acquired. While the search runs it overrides the charge pump. It also reports when the search ends without success.

Each band gets a fixed settling window. At the end of the window the controller reads two inputs: a comparator bit that is high when the control voltage is above the reference, and a phase-lock flag. Both inputs pass through two-flop synchronizers first. The controller then does one of three things:

- It declares acquisition when both inputs are high.
- It waits out another window in the same band when only the comparator is high.
- It steps one band slower when the comparator is low.

The search has a budget counted in reference-clock cycles. There are two failure outcomes. The search can reach the slowest band without acquiring. Or the budget can run out first.

Top module: `dll_band_ctrl`

## Requirements
- R1: While `rst_n` is low, `loop_rst_o` and `precharge_o` are high and `band_o` is all ones (fastest band, every current leg on). `cp_override_o`, `acquired_o`, `timeout_o` and `range_fail_o` are low.
- R2: After `rst_n` rises, `loop_rst_o` and `precharge_o` stay high together and fall on the (RST_CYC+2)-th rising clock edge. Two of those edges are spent releasing the internal reset synchronously.
- R3: The search phase begins with `band_o` at all ones. `cp_override_o` is high on every cycle of the search and low in every other phase. At most one of `cp_override_o`, `acquired_o`, `timeout_o` and `range_fail_o` is high at any time.
- R4: Each band that is left by a step was held for exactly SETTLE_CYC+1 cycles: SETTLE_CYC cycles of settling plus one decision cycle.
- R5: `band_o` changes only by decreasing by exactly one.
- R6: If the synchronized comparator bit is low at a decision, the band steps one slower, whatever the lock flag says.
- R7: If the comparator is high and lock is low at a decision, the band is kept and a new settling window starts.
- R8: If comparator and lock are both high at a decision, `acquired_o` rises on the next cycle. From then until reset, `band_o` and `acquired_o` stay fixed whatever the inputs do. The acquisition decision takes precedence over a budget expiry in the same cycle.
- R9: A failed decision (comparator low) in band 0 makes `range_fail_o` high with `band_o` held at 0 until reset.
- R10: After exactly BUDGET search cycles without acquisition, `timeout_o` goes high. `band_o` then stays fixed until reset.
- R11: A change on `vc_above_i` and `lock_i` reaches a decision only if it was present at least two rising edges before the edge that ends the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vc_above_i | input | 1 | Comparator: control voltage above reference (asynchronous) |
| lock_i | input | 1 | Phase lock flag (asynchronous) |
| band_o | output | BAND_W | Band code; all ones is fastest, 0 is slowest |
| loop_rst_o | output | 1 | Reset to the analog loop state elements |
| precharge_o | output | 1 | Request to charge the control voltage to its top level |
| cp_override_o | output | 1 | Charge pump overridden while the search runs |
| acquired_o | output | 1 | Steady state reached |
| timeout_o | output | 1 | Acquisition budget exhausted |
| range_fail_o | output | 1 | Slowest band reached without acquisition |

## Verification
The bench builds the block with RST_CYC=3, SETTLE_CYC=4, BUDGET=64 and a 3-bit band code. With those values a full descent through all eight bands takes 40 cycles and the budget expires after 64, so every outcome is reachable in a few hundred cycles. The bench sweeps the acquisition point over every band and compares the exact search length against (8-band)*(SETTLE_CYC+1). The short settling window also makes it practical to test synchronizer latency: the bench moves the input change one cycle either side of the sampling cut-off.

// File: rtl/dll_band_pkg.sv
package dll_band_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_SETTLE     = 3'd1,
    ST_EVAL       = 3'd2,
    ST_LOCKED     = 3'd3,
    ST_RANGE_FAIL = 3'd4,
    ST_TIMEOUT    = 3'd5
  } band_state_e;

endpackage

// File: rtl/dll_sync.sv
module dll_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/dll_budget_timer.sv
module dll_budget_timer #(
  parameter int BUDGET = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);

  localparam int CW = $clog2(BUDGET + 1);
  localparam logic [CW-1:0] LAST = CW'(BUDGET - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | (en_i & ~last_o);
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/dll_band_fsm.sv
module dll_band_fsm
  import dll_band_pkg::*;
#(
  parameter int BAND_W     = 3,
  parameter int RST_CYC    = 8,
  parameter int SETTLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              above_s_i,
  input  logic              lock_s_i,
  input  logic              budget_last_i,
  output band_state_e       state_o,
  output logic [BAND_W-1:0] band_o
);

  localparam int CNT_MAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  RST_LAST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0]  SET_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [BAND_W-1:0] BAND_MAX = '1;
  localparam logic [BAND_W-1:0] BAND_MIN = '0;
  localparam logic [BAND_W-1:0] BAND_ONE = BAND_W'(1);

  band_state_e       state_q, state_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              band_en;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    state_d = state_q;
    band_d  = band_q;
    band_en = 1'b0;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_RESET: begin
        cnt_en = 1'b1;
        if (cnt_q == RST_LAST) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_SETTLE: begin
        cnt_en = 1'b1;
        if (budget_last_i) begin
          state_d = ST_TIMEOUT;
        end else if (cnt_q == SET_LAST) begin
          state_d = ST_EVAL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_EVAL: begin
        if (above_s_i && lock_s_i) begin
          state_d = ST_LOCKED;
        end else if (budget_last_i) begin
          state_d = ST_TIMEOUT;
        end else if (!above_s_i) begin
          if (band_q == BAND_MIN) begin
            state_d = ST_RANGE_FAIL;
          end else begin
            band_en = 1'b1;
            band_d  = band_q - BAND_ONE;
            state_d = ST_SETTLE;
          end
        end else begin
          state_d = ST_SETTLE;
        end
      end
      default: begin
        state_d = state_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      band_q  <= BAND_MAX;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (band_en) begin
        band_q <= band_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign state_o = state_q;
  assign band_o  = band_q;

endmodule

// File: rtl/dll_band_ctrl.sv
module dll_band_ctrl
  import dll_band_pkg::*;
#(
  parameter int BAND_W      = 3,
  parameter int RST_CYC     = 8,
  parameter int SETTLE_CYC  = 64,
  parameter int BUDGET      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vc_above_i,
  input  logic              lock_i,
  output logic [BAND_W-1:0] band_o,
  output logic              loop_rst_o,
  output logic              precharge_o,
  output logic              cp_override_o,
  output logic              acquired_o,
  output logic              timeout_o,
  output logic              range_fail_o
);

  logic        rst_sync_n;
  logic [1:0]  in_sync;
  logic        above_s;
  logic        lock_s;
  logic        budget_last;
  logic        searching;
  band_state_e state;

  dll_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  dll_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({vc_above_i, lock_i}),
    .q_o   (in_sync)
  );

  assign above_s = in_sync[1];
  assign lock_s  = in_sync[0];

  dll_budget_timer #(.BUDGET(BUDGET)) u_budget (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (state == ST_RESET),
    .en_i   (searching),
    .last_o (budget_last)
  );

  dll_band_fsm #(
    .BAND_W     (BAND_W),
    .RST_CYC    (RST_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .above_s_i     (above_s),
    .lock_s_i      (lock_s),
    .budget_last_i (budget_last),
    .state_o       (state),
    .band_o        (band_o)
  );

  assign searching     = (state == ST_SETTLE) || (state == ST_EVAL);
  assign loop_rst_o    = (state == ST_RESET);
  assign precharge_o   = (state == ST_RESET);
  assign cp_override_o = searching;
  assign acquired_o    = (state == ST_LOCKED);
  assign timeout_o     = (state == ST_TIMEOUT);
  assign range_fail_o  = (state == ST_RANGE_FAIL);

endmodule

// File: rtl/dll_band_ctrl_chk.sv
module dll_band_ctrl_chk #(
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BAND_W-1:0] band_o,
  input logic              loop_rst_o,
  input logic              precharge_o,
  input logic              cp_override_o,
  input logic              acquired_o,
  input logic              timeout_o,
  input logic              range_fail_o,
  input logic              above_s,
  input logic              lock_s
);

  localparam logic [BAND_W-1:0] ONE = BAND_W'(1);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rst_o |-> (precharge_o && (band_o == '1) && !cp_override_o));

  // R3
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cp_override_o, acquired_o, timeout_o, range_fail_o}));

  // R5
  band_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_o != $past(band_o)) |-> (band_o == ($past(band_o) - ONE)));

  // R6
  step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_o != $past(band_o)) |-> !$past(above_s));

  // R8
  acq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acquired_o) |-> $past(above_s && lock_s));

  // R8
  acq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acquired_o) |-> (acquired_o && $stable(band_o)));

  // R9
  range_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_fail_o |-> (band_o == '0));

  // R10
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timeout_o) |-> (timeout_o && $stable(band_o)));

endmodule

bind dll_band_ctrl dll_band_ctrl_chk #(.BAND_W(BAND_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .band_o        (band_o),
  .loop_rst_o    (loop_rst_o),
  .precharge_o   (precharge_o),
  .cp_override_o (cp_override_o),
  .acquired_o    (acquired_o),
  .timeout_o     (timeout_o),
  .range_fail_o  (range_fail_o),
  .above_s       (above_s),
  .lock_s        (lock_s)
);

// File: tb/tb_dll_band_ctrl.sv
`timescale 1ns/1ps
module tb_dll_band_ctrl;

  localparam int BW = 3;
  localparam int RC = 3;
  localparam int SC = 4;
  localparam int BG = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vc_above;
  logic          lock;
  logic [BW-1:0] band;
  logic          loop_rst, precharge, override, acquired, timeout, range_fail;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dll_band_ctrl #(
    .BAND_W(BW), .RST_CYC(RC), .SETTLE_CYC(SC), .BUDGET(BG), .SYNC_STAGES(2)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .vc_above_i    (vc_above),
    .lock_i        (lock),
    .band_o        (band),
    .loop_rst_o    (loop_rst),
    .precharge_o   (precharge),
    .cp_override_o (override),
    .acquired_o    (acquired),
    .timeout_o     (timeout),
    .range_fail_o  (range_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cmp0, input logic lock0);
    int n;
    rst_n = 1'b0; vc_above = cmp0; lock = lock0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(loop_rst && precharge, "R1 loop reset/precharge", {loop_rst, precharge}, 3);
    chk(int'(band) == 7, "R1 band", band, 7);
    chk(!(override | acquired | timeout | range_fail), "R1 flags",
        {override, acquired, timeout, range_fail}, 0);
    rst_n = 1'b1;
    n = 0;
    @(negedge clk);
    while (loop_rst && n < 50) begin
      if (precharge !== 1'b1) chk(0, "R2 precharge follows", precharge, 1);
      n++;
      @(negedge clk);
    end
    // R2 duration
    chk(n == RC + 1, "R2 reset duration", n, RC + 1);
    chk(!precharge, "R2 precharge release", precharge, 0);
  endtask

  task automatic run_search(input int tgt, input int set_idx, input logic cmp_v,
                            input logic lock_v, output int ncyc);
    int idx; int prev; bit step_ok; bit dwell_ok; bit ovr_ok;
    ncyc = 0; idx = 0; prev = int'(band);
    step_ok = 1; dwell_ok = 1; ovr_ok = 1;
    chk(int'(band) == 7, "R3 start band", band, 7);
    while (!(acquired || timeout || range_fail) && ncyc < 400) begin
      if (!override) ovr_ok = 0;
      if (int'(band) != prev) begin
        if (int'(band) != prev - 1) step_ok = 0;
        if (idx != SC + 1) dwell_ok = 0;
        prev = int'(band);
        idx = 0;
      end
      if (int'(band) == tgt && idx == set_idx) begin
        vc_above = cmp_v; lock = lock_v;
      end
      idx++; ncyc++;
      @(negedge clk);
    end
    chk(ovr_ok, "R3 override during search", ovr_ok, 1);
    chk(step_ok, "R5 single downward steps", step_ok, 1);
    chk(dwell_ok, "R4 band dwell", dwell_ok, 1);
    chk(!override, "R3 override released", override, 0);
  endtask

  task automatic hold_check(input int exp_band, input string req);
    bit ok; ok = 1;
    for (int i = 0; i < 12; i++) begin
      vc_above = i[0]; lock = i[1];
      @(negedge clk);
      if (int'(band) != exp_band || override) ok = 0;
    end
    chk(ok, req, band, exp_band);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R8 sweep: acquisition in every band
    for (int t = 7; t >= 0; t--) begin
      do_reset(1'b0, 1'b0);
      run_search(t, 0, 1'b1, 1'b1, n);
      chk(acquired && !range_fail && !timeout, "R8 acquired", acquired, 1);
      chk(int'(band) == t, "R8 band at acquisition", band, t);
      chk(n == (8 - t) * (SC + 1), "R8 search length", n, (8 - t) * (SC + 1));
      hold_check(t, "R8 sticky after acquisition");
      chk(acquired, "R8 acquired held", acquired, 1);
    end

    // R11 input change one edge too late is missed, decided in next band
    do_reset(1'b0, 1'b0);
    run_search(5, 3, 1'b1, 1'b1, n);
    chk(acquired && int'(band) == 4, "R11 late change missed", band, 4);
    chk(n == 20, "R11 late change length", n, 20);

    // R11 input change just in time is seen
    do_reset(1'b0, 1'b0);
    run_search(5, 2, 1'b1, 1'b1, n);
    chk(acquired && int'(band) == 5, "R11 timely change seen", band, 5);
    chk(n == 15, "R11 timely change length", n, 15);

    // R6 lock high but comparator low: steps all the way; R9 range fail
    do_reset(1'b0, 1'b1);
    run_search(-1, 0, 1'b0, 1'b0, n);
    chk(!acquired, "R6 no acquisition with comparator low", acquired, 0);
    chk(range_fail && int'(band) == 0, "R9 range fail at band 0", band, 0);
    chk(n == 8 * (SC + 1), "R9 descent length", n, 8 * (SC + 1));
    hold_check(0, "R9 band 0 held");
    chk(range_fail, "R9 flag held", range_fail, 1);

    // R7 comparator high, lock low: band kept; R10 budget expiry
    do_reset(1'b1, 1'b0);
    run_search(-1, 0, 1'b0, 1'b0, n);
    chk(int'(band) == 7, "R7 band kept while above without lock", band, 7);
    chk(timeout && !acquired && !range_fail, "R10 timeout flag", timeout, 1);
    chk(n == BG, "R10 budget length", n, BG);
    hold_check(7, "R10 band frozen after timeout");
    chk(timeout, "R10 flag held", timeout, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule